// File: doc/BRIEF.md
# Thermal alarm register block

This block sits between an on-chip temperature sensor and the interrupt fabric. The sensor delivers an 8-bit temperature code together with a one-cycle sample strobe. The block keeps the most recent code in a read-only register and compares each new code with three rising and three falling threshold codes, which are packed one per byte into two words. A level produces an event when the code moves across its threshold in the watched direction, that level is enabled and the sensor core is switched on.

Each event sets a sticky status bit. Rising lanes sit four bit positions apart from bit 0, and falling lanes use the same spacing from bit 16. A single interrupt line reports any status bit whose enable is set. Software clears status bits by writing ones to a clear register, so rising and falling bits can be cleared separately. The block also holds the analog front-end configuration word and a trim word that is reloaded from fuse inputs on command. An emulation register can substitute a programmed code for the sensor code.

Access goes through a simple synchronous port with byte address, write data, write enable and combinational read data. Offsets: trim 0x00, trim reload 0x14, control 0x20, ready 0x28, current code 0x40, rising thresholds 0x50, falling thresholds 0x54, enable 0x70, status 0x74, clear 0x78, emulation 0x80.

Top module: `thermo_alarm`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: On each cycle with `sample_i` high, the current-code register (0x40) takes the new code. A write to 0x40 has no effect.
- R3: Threshold code i sits in byte i of 0x50 (bits 7:0, 15:8, 23:16). Rising status bit 4*i (bits 0, 4, 8) is set when the previous code is at or below threshold i and the sampled code is above it.
- R4: Events are only detected while control bits 1:0 equal 3 (core on). The value 2 (core off) blocks all events.
- R5: A level whose enable bit is clear sets no status bit. Rising enables are at bits 0, 4 and 8 of 0x70, with bit 12 also stored. Falling enables are at bits 16, 20 and 24.
- R6: Falling threshold i sits in byte i of 0x54. Falling status bit 16+4*i is set when the previous code is above threshold i and the sampled code is at or below it.
- R7: Status bits (0x74) stay set until a one is written to the same bit of 0x78. Writing 0x111 clears only the rising bits, and writing 0x1110000 clears only the falling bits. When a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when some status bit has its enable bit set. Removing the enable lowers `irq_o` but keeps the status bit.
- R9: Writing a value with bit 0 set to 0x14 loads `trim_fuse_i` into 0x00. A write with bit 0 clear leaves 0x00 unchanged.
- R10: Bit 0 of 0x28 reflects `sensor_ready_i`, and the other bits read zero.
- R11: The control register (0x20) stores only the core field (1:0), gain (11:8), trip mode (15:13), mux address (22:20) and reference voltage (28:24). Its stored value drives `afe_cfg_o`, so writing all ones reads back 0x1F70EF03.
- R12: Reads of unmapped offsets such as 0x44 and 0x7C return zero.
- R13: While bit 0 of 0x80 is set, a sample uses the code in bits 15:8 of 0x80 instead of `sensor_code_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| sample_i | input | 1 | Sensor sample strobe |
| sensor_code_i | input | CODE_W | Temperature code from the sensor |
| sensor_ready_i | input | 1 | Sensor ready indication |
| trim_fuse_i | input | TRIM_W | Fuse trim value |
| afe_cfg_o | output | DW | Control register contents for the sensor front end |
| irq_o | output | 1 | Interrupt request |

## Verification
The main check walks a sequence of codes against thresholds 40, 60 and 80. Codes that sit still above a threshold show that only a crossing counts, not a level. One jump over two thresholds shows that the lanes are independent. The codes 41 after 40 and 81 after 80 pin down the "at or below, then above" boundary on both sides. A full-scale swing from 0 to 255 sets all three lanes at once. Directed patterns then separate the gating sources (core off, disabled lane, masked interrupt), the rising and falling clear halves, a clear colliding with an event, and sensor versus emulated codes.

// File: rtl/thermo_alarm_pkg.sv
package thermo_alarm_pkg;
   // byte offsets of the register map
   localparam int OFS_TRIM    = 'h00;
   localparam int OFS_TRIMCTL = 'h14;
   localparam int OFS_CTRL    = 'h20;
   localparam int OFS_READY   = 'h28;
   localparam int OFS_TEMP    = 'h40;
   localparam int OFS_RISE    = 'h50;
   localparam int OFS_FALL    = 'h54;
   localparam int OFS_IEN     = 'h70;
   localparam int OFS_ISTAT   = 'h74;
   localparam int OFS_ICLR    = 'h78;
   localparam int OFS_EMUL    = 'h80;

   // control word fields: lsb and width
   localparam int CORE_LSB = 0;   localparam int CORE_W = 2;
   localparam int GAIN_LSB = 8;   localparam int GAIN_W = 4;
   localparam int TRIP_LSB = 13;  localparam int TRIP_W = 3;
   localparam int MUX_LSB  = 20;  localparam int MUX_W  = 3;
   localparam int VREF_LSB = 24;  localparam int VREF_W = 5;
   localparam int CTL_TOP  = VREF_LSB + VREF_W;

   localparam logic [CORE_W-1:0] CORE_ON = 2'b11;

   localparam logic [31:0] CTL_MASK =
      (((32'd1 << CORE_W) - 32'd1) << CORE_LSB) |
      (((32'd1 << GAIN_W) - 32'd1) << GAIN_LSB) |
      (((32'd1 << TRIP_W) - 32'd1) << TRIP_LSB) |
      (((32'd1 << MUX_W)  - 32'd1) << MUX_LSB)  |
      (((32'd1 << VREF_W) - 32'd1) << VREF_LSB);

   // emulation word: enable bit and code position
   localparam int EMU_EN_BIT   = 0;
   localparam int EMU_CODE_LSB = 8;
endpackage

// File: rtl/thermo_alarm_regfile.sv
module thermo_alarm_regfile
   import thermo_alarm_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 8,
   parameter int CODE_W = 8,
   parameter int N_LEV  = 3,
   parameter int TRIM_W = 16,
   parameter logic [DW-1:0] ENA_MASK = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en_i,
   input  logic [AW-1:0]                 addr_i,
   input  logic [DW-1:0]                 wdata_i,
   output logic [DW-1:0]                 rdata_o,
   input  logic [DW-1:0]                 stat_i,
   input  logic [CODE_W-1:0]             cur_code_i,
   input  logic                          ready_i,
   input  logic [TRIM_W-1:0]             trim_fuse_i,
   output logic [DW-1:0]                 ctrl_o,
   output logic [N_LEV-1:0][CODE_W-1:0]  rise_thr_o,
   output logic [N_LEV-1:0][CODE_W-1:0]  fall_thr_o,
   output logic [DW-1:0]                 ena_o,
   output logic [DW-1:0]                 clr_o,
   output logic                          emul_en_o,
   output logic [CODE_W-1:0]             emul_code_o
);
   localparam int THR_BITS = CODE_W * N_LEV;
   localparam logic [DW-1:0] THR_MASK = DW'((64'd1 << THR_BITS) - 64'd1);
   localparam logic [DW-1:0] EMU_MASK =
      DW'(((64'd1 << CODE_W) - 64'd1) << EMU_CODE_LSB) | DW'(64'd1 << EMU_EN_BIT);

   logic sel_trim, sel_trimctl, sel_ctrl, sel_ready, sel_temp;
   logic sel_rise, sel_fall, sel_ien, sel_istat, sel_iclr, sel_emul;

   assign sel_trim    = (addr_i == AW'(OFS_TRIM));
   assign sel_trimctl = (addr_i == AW'(OFS_TRIMCTL));
   assign sel_ctrl    = (addr_i == AW'(OFS_CTRL));
   assign sel_ready   = (addr_i == AW'(OFS_READY));
   assign sel_temp    = (addr_i == AW'(OFS_TEMP));
   assign sel_rise    = (addr_i == AW'(OFS_RISE));
   assign sel_fall    = (addr_i == AW'(OFS_FALL));
   assign sel_ien     = (addr_i == AW'(OFS_IEN));
   assign sel_istat   = (addr_i == AW'(OFS_ISTAT));
   assign sel_iclr    = (addr_i == AW'(OFS_ICLR));
   assign sel_emul    = (addr_i == AW'(OFS_EMUL));

   logic [TRIM_W-1:0] trim_q;
   logic [DW-1:0]     ctrl_q, rise_q, fall_q, ena_q, emul_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q <= '0;
         ctrl_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
         ena_q  <= '0;
         emul_q <= '0;
      end else if (wr_en_i) begin
         if (sel_trimctl && wdata_i[0]) trim_q <= trim_fuse_i;
         if (sel_ctrl) ctrl_q <= wdata_i & DW'(CTL_MASK);
         if (sel_rise) rise_q <= wdata_i & THR_MASK;
         if (sel_fall) fall_q <= wdata_i & THR_MASK;
         if (sel_ien)  ena_q  <= wdata_i & ENA_MASK;
         if (sel_emul) emul_q <= wdata_i & EMU_MASK;
      end
   end

   assign clr_o = (wr_en_i && sel_iclr) ? wdata_i : '0;

   always_comb begin
      rdata_o = '0;
      if (sel_trim)       rdata_o = DW'(trim_q);
      else if (sel_ctrl)  rdata_o = ctrl_q;
      else if (sel_ready) rdata_o = DW'(ready_i);
      else if (sel_temp)  rdata_o = DW'(cur_code_i);
      else if (sel_rise)  rdata_o = rise_q;
      else if (sel_fall)  rdata_o = fall_q;
      else if (sel_ien)   rdata_o = ena_q;
      else if (sel_istat) rdata_o = stat_i;
      else if (sel_emul)  rdata_o = emul_q;
   end

   for (genvar i = 0; i < N_LEV; i++) begin : g_thr
      assign rise_thr_o[i] = rise_q[i*CODE_W +: CODE_W];
      assign fall_thr_o[i] = fall_q[i*CODE_W +: CODE_W];
   end

   assign ctrl_o      = ctrl_q;
   assign ena_o       = ena_q;
   assign emul_en_o   = emul_q[EMU_EN_BIT];
   assign emul_code_o = emul_q[EMU_CODE_LSB +: CODE_W];
endmodule

// File: rtl/thermo_alarm_sampler.sv
module thermo_alarm_sampler #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_i,
   input  logic [CODE_W-1:0] sensor_code_i,
   input  logic              emul_en_i,
   input  logic [CODE_W-1:0] emul_code_i,
   output logic [CODE_W-1:0] new_code_o,
   output logic [CODE_W-1:0] cur_code_o
);
   logic [CODE_W-1:0] cur_q;

   assign new_code_o = emul_en_i ? emul_code_i : sensor_code_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cur_q <= '0;
      else if (sample_i) cur_q <= new_code_o;
   end

   assign cur_code_o = cur_q;
endmodule

// File: rtl/thermo_alarm_detect.sv
module thermo_alarm_detect #(
   parameter int DW         = 32,
   parameter int CODE_W     = 8,
   parameter int N_LEV      = 3,
   parameter int LANE       = 4,
   parameter int FALL_SHIFT = 16
) (
   input  logic                          sample_i,
   input  logic                          core_on_i,
   input  logic [CODE_W-1:0]             prev_code_i,
   input  logic [CODE_W-1:0]             new_code_i,
   input  logic [N_LEV-1:0][CODE_W-1:0]  rise_thr_i,
   input  logic [N_LEV-1:0][CODE_W-1:0]  fall_thr_i,
   input  logic [DW-1:0]                 ena_i,
   output logic [DW-1:0]                 evt_o
);
   logic                 live;
   logic [N_LEV-1:0]     rise_hit, fall_hit;
   logic                 unused_ena;

   assign live       = sample_i && core_on_i;
   assign unused_ena = ^ena_i;

   for (genvar i = 0; i < N_LEV; i++) begin : g_lev
      assign rise_hit[i] = live && ena_i[LANE*i]
                         && (prev_code_i <= rise_thr_i[i])
                         && (new_code_i  >  rise_thr_i[i]);
      assign fall_hit[i] = live && ena_i[FALL_SHIFT + LANE*i]
                         && (prev_code_i >  fall_thr_i[i])
                         && (new_code_i  <= fall_thr_i[i]);
   end

   always_comb begin
      evt_o = '0;
      for (int i = 0; i < N_LEV; i++) begin
         evt_o[LANE*i]              = rise_hit[i];
         evt_o[FALL_SHIFT + LANE*i] = fall_hit[i];
      end
   end
endmodule

// File: rtl/thermo_alarm_status.sv
module thermo_alarm_status #(
   parameter int DW = 32,
   parameter logic [DW-1:0] STAT_MASK = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] evt_i,
   input  logic [DW-1:0] clr_i,
   input  logic [DW-1:0] ena_i,
   output logic [DW-1:0] stat_o,
   output logic          irq_o
);
   logic [DW-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= ((stat_q & ~clr_i) | evt_i) & STAT_MASK;
   end

   assign stat_o = stat_q;
   assign irq_o  = |(stat_q & ena_i);
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
   import thermo_alarm_pkg::*;
#(
   parameter int DW         = 32,
   parameter int AW         = 8,
   parameter int CODE_W     = 8,
   parameter int N_LEV      = 3,
   parameter int LANE       = 4,
   parameter int FALL_SHIFT = 16,
   parameter int TRIM_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              sample_i,
   input  logic [CODE_W-1:0] sensor_code_i,
   input  logic              sensor_ready_i,
   input  logic [TRIM_W-1:0] trim_fuse_i,
   output logic [DW-1:0]     afe_cfg_o,
   output logic              irq_o
);
   function automatic logic [DW-1:0] lane_bits(input int base, input int n);
      logic [DW-1:0] m;
      m = '0;
      for (int i = 0; i < n; i++) m[base + LANE*i] = 1'b1;
      return m;
   endfunction

   // rising enables include one spare level above the thresholds
   localparam logic [DW-1:0] ENA_MASK  = lane_bits(0, N_LEV + 1) | lane_bits(FALL_SHIFT, N_LEV);
   localparam logic [DW-1:0] STAT_MASK = lane_bits(0, N_LEV)     | lane_bits(FALL_SHIFT, N_LEV);

   if (DW < CTL_TOP) begin : g_err_dw
      $error("data width too small for control fields");
   end
   if (CODE_W * N_LEV > DW) begin : g_err_thr
      $error("threshold codes do not fit one word");
   end
   if (LANE * N_LEV >= FALL_SHIFT) begin : g_err_lane
      $error("rising lanes overlap falling lanes");
   end
   if (FALL_SHIFT + LANE * (N_LEV - 1) >= DW) begin : g_err_fall
      $error("falling lanes exceed data width");
   end
   if (TRIM_W > DW || EMU_CODE_LSB + CODE_W > DW) begin : g_err_misc
      $error("trim or emulation field exceeds data width");
   end

   logic [DW-1:0]                ctrl_w, ena_w, clr_w, evt_w, stat_w;
   logic [N_LEV-1:0][CODE_W-1:0] rise_thr_w, fall_thr_w;
   logic [CODE_W-1:0]            cur_code_w, new_code_w, emul_code_w;
   logic                         emul_en_w, core_on_w;

   thermo_alarm_regfile #(
      .DW(DW), .AW(AW), .CODE_W(CODE_W), .N_LEV(N_LEV),
      .TRIM_W(TRIM_W), .ENA_MASK(ENA_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(bus_wr_en), .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
      .stat_i(stat_w), .cur_code_i(cur_code_w), .ready_i(sensor_ready_i),
      .trim_fuse_i(trim_fuse_i), .ctrl_o(ctrl_w),
      .rise_thr_o(rise_thr_w), .fall_thr_o(fall_thr_w),
      .ena_o(ena_w), .clr_o(clr_w),
      .emul_en_o(emul_en_w), .emul_code_o(emul_code_w)
   );

   thermo_alarm_sampler #(.CODE_W(CODE_W)) u_samp (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
      .sensor_code_i(sensor_code_i), .emul_en_i(emul_en_w), .emul_code_i(emul_code_w),
      .new_code_o(new_code_w), .cur_code_o(cur_code_w)
   );

   assign core_on_w = (ctrl_w[CORE_LSB +: CORE_W] == CORE_ON);

   thermo_alarm_detect #(
      .DW(DW), .CODE_W(CODE_W), .N_LEV(N_LEV), .LANE(LANE), .FALL_SHIFT(FALL_SHIFT)
   ) u_det (
      .sample_i(sample_i), .core_on_i(core_on_w),
      .prev_code_i(cur_code_w), .new_code_i(new_code_w),
      .rise_thr_i(rise_thr_w), .fall_thr_i(fall_thr_w),
      .ena_i(ena_w), .evt_o(evt_w)
   );

   thermo_alarm_status #(.DW(DW), .STAT_MASK(STAT_MASK)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .clr_i(clr_w), .ena_i(ena_w),
      .stat_o(stat_w), .irq_o(irq_o)
   );

   assign afe_cfg_o = ctrl_w;
endmodule

// File: rtl/thermo_alarm_chk.sv
module thermo_alarm_chk
   import thermo_alarm_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 8,
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [AW-1:0]     addr,
   input logic              sample,
   input logic [DW-1:0]     stat,
   input logic [DW-1:0]     ctrl,
   input logic [CODE_W-1:0] cur_code,
   input logic              irq
);
   logic clr_wr;
   assign clr_wr = wr_en && (addr == AW'(OFS_ICLR));

   // R7: a status bit only drops on a clear write
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((stat & $past(stat)) == $past(stat)));

   // R4: no new status bit while the core is off
   a_r4_core_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CORE_LSB +: CORE_W] != CORE_ON) |=> ((stat & ~$past(stat)) == '0));

   // R3: new status bits only come from a sample
   a_r3_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> ((stat & ~$past(stat)) == '0));

   // R2: current code holds between samples
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> $stable(cur_code));

   // R8: no interrupt without a pending status bit
   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == '0) |-> !irq);
endmodule

bind thermo_alarm thermo_alarm_chk #(.DW(DW), .AW(AW), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
   .sample(sample_i), .stat(stat_w), .ctrl(ctrl_w), .cur_code(cur_code_w), .irq(irq_o)
);

// File: tb/thermo_alarm_bench.sv
`timescale 1ns/100ps
module thermo_alarm_bench;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr_en = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          sample_i = 1'b0;
   logic [7:0]    sensor_code_i = '0;
   logic          sensor_ready_i = 1'b0;
   logic [15:0]   trim_fuse_i = 16'hABCD;
   logic [DW-1:0] afe_cfg_o;
   logic          irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   thermo_alarm u_thermo_alarm (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_i(sample_i),
      .sensor_code_i(sensor_code_i), .sensor_ready_i(sensor_ready_i),
      .trim_fuse_i(trim_fuse_i), .afe_cfg_o(afe_cfg_o), .irq_o(irq_o)
   );

   // sample codes and the rising status expected after each (thresholds 40/60/80, status cleared before each)
   localparam int NV = 12;
   localparam logic [7:0] V_CODE [NV] = '{8'd30, 8'd50, 8'd55, 8'd85, 8'd100, 8'd40,
                                          8'd41, 8'd80, 8'd81, 8'd255, 8'd0, 8'd255};
   localparam logic [31:0] V_STAT [NV] = '{32'h000, 32'h001, 32'h000, 32'h110, 32'h000, 32'h000,
                                           32'h001, 32'h010, 32'h100, 32'h000, 32'h000, 32'h111};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic do_sample(input logic [7:0] c);
      @(negedge clk);
      sample_i = 1'b1; sensor_code_i = c;
      @(negedge clk);
      sample_i = 1'b0;
   endtask

   task automatic sample_and_clear(input logic [7:0] c, input logic [31:0] m);
      @(negedge clk);
      sample_i = 1'b1; sensor_code_i = c;
      bus_wr_en = 1'b1; bus_addr = 8'h78; bus_wdata = m;
      @(negedge clk);
      sample_i = 1'b0; bus_wr_en = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(8'h20, r); chk("R1 ctrl", r, 0);
      bus_rd(8'h40, r); chk("R1 temp", r, 0);
      bus_rd(8'h50, r); chk("R1 rise thr", r, 0);
      bus_rd(8'h74, r); chk("R1 status", r, 0);
      bus_rd(8'h00, r); chk("R1 trim", r, 0);
      chk("R1 irq", {31'b0, irq_o}, 0);

      // R10 ready flag
      bus_rd(8'h28, r); chk("R10 not ready", r, 0);
      sensor_ready_i = 1'b1;
      bus_rd(8'h28, r); chk("R10 ready", r, 1);

      // R11 control field mask
      bus_wr(8'h20, 32'hFFFF_FFFF);
      bus_rd(8'h20, r); chk("R11 ctrl readback", r, 32'h1F70_EF03);
      chk("R11 afe_cfg_o", afe_cfg_o, 32'h1F70_EF03);
      bus_wr(8'h20, 32'h0060_0003);
      chk("R11 afe_cfg_o on", afe_cfg_o, 32'h0060_0003);

      // R3/R8 vector walk
      bus_wr(8'h50, 32'h0050_3C28);
      bus_wr(8'h70, 32'h0000_0111);
      for (int i = 0; i < NV; i++) begin
         bus_wr(8'h78, 32'h111);
         do_sample(V_CODE[i]);
         bus_rd(8'h74, r);
         chk($sformatf("R3 vector %0d status", i), r, V_STAT[i]);
         chk($sformatf("R8 vector %0d irq", i), {31'b0, irq_o}, {31'b0, V_STAT[i] != 0});
      end

      // R2 current code read-only
      bus_wr(8'h40, 32'h77);
      bus_rd(8'h40, r); chk("R2 write ignored", r, 32'hFF);
      do_sample(8'h10);
      bus_rd(8'h40, r); chk("R2 sample captured", r, 32'h10);

      // R12 unmapped reads
      bus_rd(8'h44, r); chk("R12 0x44", r, 0);
      bus_rd(8'h7C, r); chk("R12 0x7C", r, 0);

      // R4 core off
      bus_wr(8'h78, 32'h111);
      bus_wr(8'h20, 32'h2);
      do_sample(8'h90);
      bus_rd(8'h74, r); chk("R4 core off status", r, 0);
      chk("R4 core off irq", {31'b0, irq_o}, 0);
      bus_wr(8'h20, 32'h3);

      // R5 enable gating, R8 masking
      bus_wr(8'h70, 32'h001);
      do_sample(8'h10);
      do_sample(8'h45);
      bus_rd(8'h74, r); chk("R5 only enabled lane", r, 32'h001);
      chk("R8 irq set", {31'b0, irq_o}, 1);
      bus_wr(8'h70, 32'h000);
      chk("R8 irq masked", {31'b0, irq_o}, 0);
      bus_rd(8'h74, r); chk("R8 status kept", r, 32'h001);
      bus_wr(8'h70, 32'h001);
      bus_wr(8'h78, 32'h111);
      bus_rd(8'h74, r); chk("R7 cleared", r, 0);

      // R7 clear colliding with event
      do_sample(8'h10);
      do_sample(8'h30);
      bus_rd(8'h74, r); chk("R7 event set", r, 32'h001);
      do_sample(8'h10);
      sample_and_clear(8'h30, 32'h111);
      bus_rd(8'h74, r); chk("R7 event wins clear", r, 32'h001);
      bus_wr(8'h78, 32'h111);
      bus_rd(8'h74, r); chk("R7 clear alone", r, 0);

      // R6 falling events, R7 separate clear halves
      bus_wr(8'h54, 32'h0000_0032);
      bus_wr(8'h70, 32'h0001_0000);
      do_sample(8'h40);
      bus_rd(8'h74, r); chk("R6 no fall from below", r, 0);
      do_sample(8'h20);
      bus_rd(8'h74, r); chk("R6 fall status", r, 32'h0001_0000);
      chk("R6 fall irq", {31'b0, irq_o}, 1);
      bus_wr(8'h78, 32'h111);
      bus_rd(8'h74, r); chk("R7 rising clear keeps fall", r, 32'h0001_0000);
      bus_wr(8'h78, 32'h0111_0000);
      bus_rd(8'h74, r); chk("R7 fall clear", r, 0);
      chk("R7 irq low", {31'b0, irq_o}, 0);

      // R9 trim reload
      bus_wr(8'h14, 32'h0);
      bus_rd(8'h00, r); chk("R9 no reload", r, 0);
      bus_wr(8'h14, 32'h1);
      bus_rd(8'h00, r); chk("R9 reload", r, 32'hABCD);

      // R13 emulation
      bus_wr(8'h80, 32'h0000_5A01);
      bus_rd(8'h80, r); chk("R13 emul readback", r, 32'h0000_5A01);
      do_sample(8'h11);
      bus_rd(8'h40, r); chk("R13 emulated code", r, 32'h5A);
      bus_wr(8'h80, 32'h0);
      do_sample(8'h11);
      bus_rd(8'h40, r); chk("R13 sensor code", r, 32'h11);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule